// File: doc/BRIEF.md
# Two-Channel Serial Port Interrupt and Register Block

This block is the host-side register file and interrupt logic of a serial controller with two channels, a console channel (A) and an auxiliary channel (B). The host reaches it through a simple single-cycle register port. Each channel has a status register, a command register and a holding register. One shared address reads the interrupt status and writes the interrupt mask, and a single interrupt line goes to the host.

Each channel has a one-character receive buffer. A receive strobe loads the buffer, and a host read of the holding register empties it. Transmit-ready interrupts are not taken from a transmitter level. A periodic tick input is divided by two. On each divided tick, if the host has enabled either transmit-ready interrupt, both transmit-ready status bits are raised. A host write to a holding register sends the character out as a one-cycle strobe and clears that channel's transmit-ready bit. A command write that sets the transmit-disable bit sends a one-cycle flush request for that channel.

Serial framing and baud generation belong to other blocks. The mode, counter/timer and output-port addresses accept accesses and ignore them.

Top module: `duart_irq_regs`

## Requirements
- R1: After reset the interrupt line is low, the interrupt status reads 0x00, the mask is 0x00, both receive buffers are empty and the tick divider phase is zero.
- R2: The interrupt status byte uses bit 0 for channel A transmit-ready, bit 1 for channel A receive-ready, bit 4 for channel B transmit-ready and bit 5 for channel B receive-ready. The other bits read 0. A write to offset 0x2C loads the mask, which keeps only those four bit positions. A read of 0x2C returns the status.
- R3: A receive strobe on a channel sets that channel's receive-ready status bit and raises the interrupt line in the next cycle, but only when the matching mask bit is 1. With the mask bit at 0 neither changes.
- R4: A status read (channel A at 0x0C, channel B at 0x4C) returns bit 0 = receive buffer holds a character, bit 2 = 1, and all other bits 0. A read of channel A's status drops the interrupt line on that clock edge. A read of channel B's status leaves the line unchanged.
- R5: A write to a holding register (A at 0x1C, B at 0x5C) drives that channel's transmit strobe high for exactly the following cycle, with the written byte on its character output. It also clears that channel's own transmit-ready status bit (bit 0 for A, bit 4 for B).
- R6: A read of a holding register returns the buffered character, empties the buffer and clears that channel's receive-ready status bit.
- R7: Periodic ticks are counted modulo 2. On every second tick, if mask bit 0 or mask bit 4 is set, status bits 0 and 4 are both set and the interrupt line is raised. A single tick changes nothing visible.
- R8: A write to a command register (A at 0x14, B at 0x54) with bit 3 set pulses that channel's flush request for exactly the following cycle. A command write with bit 3 clear pulses nothing.
- R9: Reads of any other offset return 0x00. Writes to any other offset change neither the mask, the status, the interrupt line nor any output.
- R10: A receive strobe overwrites any character already in the buffer. When a set event and a clear of the same status bit fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Register access in this cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Register byte offset |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid in the cycle of the read |
| rx_stb_a | input | 1 | Channel A character received |
| rx_char_a | input | 8 | Channel A received character |
| rx_stb_b | input | 1 | Channel B character received |
| rx_char_b | input | 8 | Channel B received character |
| tick | input | 1 | Periodic tick, one cycle per event |
| tx_stb_a | output | 1 | Channel A character to send |
| tx_char_a | output | 8 | Channel A character |
| tx_stb_b | output | 1 | Channel B character to send |
| tx_char_b | output | 8 | Channel B character |
| flush_a | output | 1 | Channel A output flush request |
| flush_b | output | 1 | Channel B output flush request |
| irq | output | 1 | Interrupt line to host |

## Verification
Read data is combinational, so the bench samples `host_rdata` one time unit after it presents a read, before the clock edge that applies the read's side effects. Every state change (status bits, interrupt line, buffer flags) and every output pulse (transmit strobe, flush request) is registered. These results are due one edge after their stimulus, so the bench checks them at the falling edge that follows that edge. A pulse is sampled there and checked again one cycle later to confirm it has dropped. The mask sweep sends ticks in pairs only, so the divider phase at each check is known from the tick count alone.

// File: rtl/duart_pkg.sv
package duart_pkg;

  localparam int REG_W = 8;

  // register offsets (host byte addresses)
  localparam logic [7:0] OFF_STAT_A = 8'h0C;
  localparam logic [7:0] OFF_CMD_A  = 8'h14;
  localparam logic [7:0] OFF_HOLD_A = 8'h1C;
  localparam logic [7:0] OFF_INT    = 8'h2C;
  localparam logic [7:0] OFF_STAT_B = 8'h4C;
  localparam logic [7:0] OFF_CMD_B  = 8'h54;
  localparam logic [7:0] OFF_HOLD_B = 8'h5C;

  // interrupt status / mask bit positions
  localparam int BIT_TXA = 0;
  localparam int BIT_RXA = 1;
  localparam int BIT_TXB = 4;
  localparam int BIT_RXB = 5;
  localparam logic [REG_W-1:0] INT_USED = 8'h33;

  // command register transmit-disable bit
  localparam int BIT_TXOFF = 3;

  typedef struct packed {
    logic stat_a;
    logic cmd_a;
    logic hold_a;
    logic intr;
    logic stat_b;
    logic cmd_b;
    logic hold_b;
  } reg_hit_t;

  function automatic logic [REG_W-1:0] status_byte(input logic rx_full);
    status_byte = '0;
    status_byte[2] = 1'b1;
    status_byte[0] = rx_full;
  endfunction

  function automatic logic [REG_W-1:0] int_next(input logic [REG_W-1:0] cur,
                                                input logic [REG_W-1:0] set,
                                                input logic [REG_W-1:0] clr);
    int_next = ((cur & ~clr) | set) & INT_USED;
  endfunction

endpackage

// File: rtl/duart_addr_dec.sv
module duart_addr_dec #(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0]   addr,
  output duart_pkg::reg_hit_t hit
);
  import duart_pkg::*;

  function automatic logic at(input logic [ADDR_W-1:0] a, input logic [7:0] off);
    at = (a == ADDR_W'(off));
  endfunction

  always_comb begin
    hit.stat_a = at(addr, OFF_STAT_A);
    hit.cmd_a  = at(addr, OFF_CMD_A);
    hit.hold_a = at(addr, OFF_HOLD_A);
    hit.intr   = at(addr, OFF_INT);
    hit.stat_b = at(addr, OFF_STAT_B);
    hit.cmd_b  = at(addr, OFF_CMD_B);
    hit.hold_b = at(addr, OFF_HOLD_B);
  end
endmodule

// File: rtl/duart_rx_slot.sv
module duart_rx_slot #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CHAR_W-1:0] din,
  input  logic              take,
  output logic              full,
  output logic [CHAR_W-1:0] dout
);
  // a load in the same cycle as a take keeps the new character
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      dout <= '0;
    end else if (load) begin
      full <= 1'b1;
      dout <= din;
    end else if (take) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/duart_tick_div.sv
module duart_tick_div #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic fire
);
  localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt;

  assign fire = tick && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (fire) cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/duart_irq_regs.sv
module duart_irq_regs #(
  parameter int ADDR_W   = 8,
  parameter int TICK_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic              rx_stb_a,
  input  logic [7:0]        rx_char_a,
  input  logic              rx_stb_b,
  input  logic [7:0]        rx_char_b,
  input  logic              tick,
  output logic              tx_stb_a,
  output logic [7:0]        tx_char_a,
  output logic              tx_stb_b,
  output logic [7:0]        tx_char_b,
  output logic              flush_a,
  output logic              flush_b,
  output logic              irq
);
  import duart_pkg::*;

  localparam int NCH = 2;

  reg_hit_t hit;
  duart_addr_dec #(.ADDR_W(ADDR_W)) u_dec (.addr(host_addr), .hit(hit));

  // named access events
  logic ev_rd, ev_wr;
  logic ev_rd_stat_a, ev_rd_hold_a, ev_rd_hold_b;
  logic ev_wr_hold_a, ev_wr_hold_b, ev_wr_mask;
  logic ev_flush_a, ev_flush_b;
  logic ev_tick_fire;

  assign ev_rd        = host_sel && !host_wr;
  assign ev_wr        = host_sel &&  host_wr;
  assign ev_rd_stat_a = ev_rd && hit.stat_a;
  assign ev_rd_hold_a = ev_rd && hit.hold_a;
  assign ev_rd_hold_b = ev_rd && hit.hold_b;
  assign ev_wr_hold_a = ev_wr && hit.hold_a;
  assign ev_wr_hold_b = ev_wr && hit.hold_b;
  assign ev_wr_mask   = ev_wr && hit.intr;
  assign ev_flush_a   = ev_wr && hit.cmd_a && host_wdata[BIT_TXOFF];
  assign ev_flush_b   = ev_wr && hit.cmd_b && host_wdata[BIT_TXOFF];

  duart_tick_div #(.DIV(TICK_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .tick(tick), .fire(ev_tick_fire)
  );

  // receive buffers, one per channel
  logic [NCH-1:0]       rx_load, rx_take, rx_full;
  logic [NCH-1:0][7:0]  rx_din, rx_dout;

  assign rx_load = {rx_stb_b, rx_stb_a};
  assign rx_take = {ev_rd_hold_b, ev_rd_hold_a};
  assign rx_din  = {rx_char_b, rx_char_a};

  for (genvar c = 0; c < NCH; c++) begin : g_rx
    duart_rx_slot #(.CHAR_W(REG_W)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .load(rx_load[c]), .din(rx_din[c]), .take(rx_take[c]),
      .full(rx_full[c]), .dout(rx_dout[c])
    );
  end

  // interrupt status and mask
  logic [7:0] int_mask, int_stat;
  logic [7:0] set_vec, clr_vec;
  logic       any_set;

  always_comb begin
    set_vec = '0;
    clr_vec = '0;
    set_vec[BIT_RXA] = rx_stb_a && int_mask[BIT_RXA];
    set_vec[BIT_RXB] = rx_stb_b && int_mask[BIT_RXB];
    if (ev_tick_fire && (int_mask[BIT_TXA] || int_mask[BIT_TXB])) begin
      set_vec[BIT_TXA] = 1'b1;
      set_vec[BIT_TXB] = 1'b1;
    end
    clr_vec[BIT_TXA] = ev_wr_hold_a;
    clr_vec[BIT_TXB] = ev_wr_hold_b;
    clr_vec[BIT_RXA] = ev_rd_hold_a;
    clr_vec[BIT_RXB] = ev_rd_hold_b;
  end

  assign any_set = |set_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_mask <= '0;
      int_stat <= '0;
      irq      <= 1'b0;
    end else begin
      if (ev_wr_mask) int_mask <= host_wdata & INT_USED;
      int_stat <= int_next(int_stat, set_vec, clr_vec);
      if (any_set)           irq <= 1'b1;
      else if (ev_rd_stat_a) irq <= 1'b0;
    end
  end

  // transmit strobes and flush requests
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_stb_a  <= 1'b0;
      tx_stb_b  <= 1'b0;
      tx_char_a <= '0;
      tx_char_b <= '0;
      flush_a   <= 1'b0;
      flush_b   <= 1'b0;
    end else begin
      tx_stb_a <= ev_wr_hold_a;
      tx_stb_b <= ev_wr_hold_b;
      if (ev_wr_hold_a) tx_char_a <= host_wdata;
      if (ev_wr_hold_b) tx_char_b <= host_wdata;
      flush_a <= ev_flush_a;
      flush_b <= ev_flush_b;
    end
  end

  // read data
  always_comb begin
    host_rdata = '0;
    if (ev_rd) begin
      if (hit.stat_a)      host_rdata = status_byte(rx_full[0]);
      else if (hit.stat_b) host_rdata = status_byte(rx_full[1]);
      else if (hit.hold_a) host_rdata = rx_dout[0];
      else if (hit.hold_b) host_rdata = rx_dout[1];
      else if (hit.intr)   host_rdata = int_stat;
    end
  end

endmodule

// File: rtl/duart_irq_chk.sv
module duart_irq_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_sel,
  input logic              host_wr,
  input logic [ADDR_W-1:0] host_addr,
  input logic              cmd_off_bit,
  input logic [7:0]        host_rdata,
  input logic              rx_stb_a,
  input logic              rx_stb_b,
  input logic              ev_tick_fire,
  input logic              tx_stb_a,
  input logic              flush_a,
  input logic              irq
);
  logic rd_stat_a, wr_cmd_a, wr_hold_a;
  assign rd_stat_a = host_sel && !host_wr && host_addr == ADDR_W'(8'h0C);
  assign wr_cmd_a  = host_sel &&  host_wr && host_addr == ADDR_W'(8'h14);
  assign wr_hold_a = host_sel &&  host_wr && host_addr == ADDR_W'(8'h1C);

  // R8: a flush request only follows a command write with the disable bit
  a_r8_flush_cause: assert property (@(posedge clk) disable iff (!rst_n)
    flush_a |-> $past(wr_cmd_a && cmd_off_bit));

  // R5: a transmit strobe only follows a holding register write
  a_r5_tx_cause: assert property (@(posedge clk) disable iff (!rst_n)
    tx_stb_a |-> $past(wr_hold_a));

  // R4: a quiet status A read drops the interrupt line
  a_r4_stat_a_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat_a && !rx_stb_a && !rx_stb_b && !ev_tick_fire) |=> !irq);

  // R4: status byte shape
  a_r4_stat_shape: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat_a |-> (host_rdata[7:3] == 5'd0 && host_rdata[2] && !host_rdata[1]));

  // R3 / R7: the line only rises after a receive or a divided tick
  a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(rx_stb_a || rx_stb_b || ev_tick_fire));
endmodule

bind duart_irq_regs duart_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
  .host_addr(host_addr), .cmd_off_bit(host_wdata[3]), .host_rdata(host_rdata),
  .rx_stb_a(rx_stb_a), .rx_stb_b(rx_stb_b), .ev_tick_fire(ev_tick_fire),
  .tx_stb_a(tx_stb_a), .flush_a(flush_a), .irq(irq)
);

// File: tb/test_duart_irq_regs.sv
`timescale 1ns/100ps
module test_duart_irq_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_sel = 1'b0, host_wr = 1'b0;
  logic [7:0] host_addr = '0, host_wdata = '0;
  logic [7:0] host_rdata;
  logic       rx_stb_a = 1'b0, rx_stb_b = 1'b0, tick = 1'b0;
  logic [7:0] rx_char_a = '0, rx_char_b = '0;
  logic       tx_stb_a, tx_stb_b, flush_a, flush_b, irq;
  logic [7:0] tx_char_a, tx_char_b;

  always #2.5 clk = ~clk;

  duart_irq_regs i_duart_irq_regs (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .rx_stb_a(rx_stb_a), .rx_char_a(rx_char_a), .rx_stb_b(rx_stb_b),
    .rx_char_b(rx_char_b), .tick(tick), .tx_stb_a(tx_stb_a),
    .tx_char_a(tx_char_a), .tx_stb_b(tx_stb_b), .tx_char_b(tx_char_b),
    .flush_a(flush_a), .flush_b(flush_b), .irq(irq)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    host_sel = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_sel = 1'b0; host_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    host_sel = 1'b1; host_wr = 1'b0; host_addr = a;
    #1 d = host_rdata;
    @(negedge clk);
    host_sel = 1'b0;
  endtask

  task automatic rx(input bit chb, input logic [7:0] c);
    @(negedge clk);
    if (chb) begin rx_stb_b = 1'b1; rx_char_b = c; end
    else     begin rx_stb_a = 1'b1; rx_char_a = c; end
    @(negedge clk);
    rx_stb_a = 1'b0; rx_stb_b = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  // mask byte from 4 enable bits: {rxb, txb, rxa, txa}
  function automatic logic [7:0] mask_of(input logic [3:0] m);
    return {2'b00, m[3], m[2], 2'b00, m[1], m[0]};
  endfunction

  // status after rx on both channels and one divided tick
  function automatic logic [7:0] exp_after(input logic [7:0] mk);
    logic [7:0] e;
    e = mk & 8'h22;
    if ((mk & 8'h11) != 0) e = e + 8'h11;
    return e;
  endfunction

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {7'd0, irq}, 8'h00);
    rd(8'h2C, d); chk("R1 status", d, 8'h00);
    rd(8'h0C, d); chk("R1 stat A", d, 8'h04);
    rd(8'h4C, d); chk("R1 stat B", d, 8'h04);
    chk("R1 outputs", {4'd0, tx_stb_a, tx_stb_b, flush_a, flush_b}, 8'h00);

    // R3 masked-off receive, R4 buffer flag, R6 holding read
    rx(0, 8'h5A);
    chk("R3 irq masked off", {7'd0, irq}, 8'h00);
    rd(8'h2C, d); chk("R3 status masked off", d, 8'h00);
    rd(8'h0C, d); chk("R4 stat A full", d, 8'h05);
    rd(8'h1C, d); chk("R6 hold A data", d, 8'h5A);
    rd(8'h0C, d); chk("R6 stat A emptied", d, 8'h04);

    // R7 divide by two
    wr(8'h2C, 8'h11);
    pulse_tick();
    rd(8'h2C, d); chk("R7 single tick", d, 8'h00);
    chk("R7 irq after single tick", {7'd0, irq}, 8'h00);
    pulse_tick();
    rd(8'h2C, d); chk("R7 second tick", d, 8'h11);
    chk("R7 irq raised", {7'd0, irq}, 8'h01);

    // R5 holding write clears own tx bit
    wr(8'h5C, 8'h77);
    chk("R5 tx strobe B", {6'd0, tx_stb_a, tx_stb_b}, 8'h01);
    chk("R5 tx char B", tx_char_b, 8'h77);
    @(negedge clk);
    chk("R5 strobe one cycle", {7'd0, tx_stb_b}, 8'h00);
    rd(8'h2C, d); chk("R5 clears bit4 only", d, 8'h01);
    rd(8'h4C, d);
    chk("R4 stat B keeps irq", {7'd0, irq}, 8'h01);
    rd(8'h0C, d);
    chk("R4 stat A drops irq", {7'd0, irq}, 8'h00);
    wr(8'h1C, 8'hC3);
    chk("R5 tx char A", tx_char_a, 8'hC3);
    chk("R5 tx strobe A", {7'd0, tx_stb_a}, 8'h01);
    rd(8'h2C, d); chk("R5 clears bit0", d, 8'h00);

    // R8 flush requests
    wr(8'h14, 8'h08);
    chk("R8 flush A", {6'd0, flush_a, flush_b}, 8'h02);
    @(negedge clk);
    chk("R8 flush one cycle", {7'd0, flush_a}, 8'h00);
    wr(8'h54, 8'h07);
    chk("R8 no flush without bit3", {6'd0, flush_a, flush_b}, 8'h00);
    wr(8'h54, 8'h0F);
    chk("R8 flush B", {6'd0, flush_a, flush_b}, 8'h01);

    // R9 unmapped accesses
    wr(8'h04, 8'hFF);
    wr(8'h34, 8'h22);
    wr(8'h24, 8'hFF);
    chk("R9 no outputs", {5'd0, tx_stb_a, tx_stb_b, irq}, 8'h00);
    rx(0, 8'h10);
    rd(8'h2C, d); chk("R9 mask untouched", d, 8'h00);
    rd(8'h04, d); chk("R9 read 0x04", d, 8'h00);
    rd(8'h24, d); chk("R9 read 0x24", d, 8'h00);
    rd(8'h3C, d); chk("R9 read 0x3C", d, 8'h00);
    rd(8'h74, d); chk("R9 read 0x74", d, 8'h00);
    rd(8'h1C, d);

    // R10 overwrite
    rx(1, 8'h11);
    rx(1, 8'h22);
    rd(8'h5C, d); chk("R10 newest char", d, 8'h22);
    rd(8'h4C, d); chk("R10 stat B emptied", d, 8'h04);

    // R2/R3/R7 mask sweep
    for (int m = 0; m < 16; m++) begin
      logic [7:0] mk;
      mk = mask_of(4'(m));
      rd(8'h1C, d); rd(8'h5C, d);
      wr(8'h1C, 8'h00); wr(8'h5C, 8'h00);
      rd(8'h0C, d);
      rd(8'h2C, d); chk("R2 cleared before sweep step", d, 8'h00);
      wr(8'h2C, mk | 8'hCC);
      rx(0, 8'(8'h40 + m));
      rx(1, 8'(8'h80 + m));
      pulse_tick(); pulse_tick();
      rd(8'h2C, d); chk("R2 status layout", d, exp_after(mk));
      chk("R3 irq from mask", {7'd0, irq}, {7'd0, exp_after(mk) != 8'h00});
      rd(8'h0C, d); chk("R4 stat A after rx", d, 8'h05);
      chk("R4 irq dropped", {7'd0, irq}, 8'h00);
    end

    done = 1;
    summary();
  end
endmodule